// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Tags

This block receives asynchronous serial characters. It takes its timing from a tick that pulses at 16 times the bit rate. The line idles high. A character begins with a low start bit. The receiver confirms the start bit at mid-bit, then samples each later bit at its centre.

The frame shape is set by configuration inputs:
- word length, from 5 to 8 bits;
- an optional parity bit, even or odd;
- one or two stop bits.

Each character is written into a 16-entry first-in first-out queue. Four error tags are stored with it: parity error, framing error, break and overrun. A reader therefore knows which character each error belongs to, with no separate status registers to poll. The queue head is always shown on the outputs. A read strobe removes the head entry.

Top module: `uart_rx_tag`

## Requirements
- R1: A low level seen on a tick arms the receiver. The line is sampled again on the 8th tick of the start bit, counting the arming tick as the first. If the line is high at that point, the receiver returns to idle and stores nothing.
- R2: `cfg_wlen` selects the word length: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. Bits arrive least significant first. They appear right-aligned on `rd_data`, and the unused upper bits read zero.
- R3: A parity bit follows the data only when `cfg_par_en` is 1. `cfg_par_odd` = 0 expects an even count of ones over data plus parity; 1 expects an odd count. A mismatch sets `rd_par_err`. With parity disabled, `rd_par_err` is always 0.
- R4: `cfg_stop2` = 1 makes the receiver sample two stop bits; 0 makes it sample one. `rd_frm_err` is set when any sampled stop bit is low.
- R5: When every sample of a frame is low, the character is stored with data zero and with `rd_brk` and `rd_frm_err` set. No new start is accepted until the line has gone high.
- R6: The queue holds 16 characters and presents its head on `rd_data` and the flag outputs while `rd_valid` is 1. A `rd_en` pulse while the queue is empty has no effect.
- R7: A character that completes while the queue is full is discarded. The next character that is stored carries `rd_ovr` = 1, and the following ones carry 0.
- R8: After reset, `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idles high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_wlen | input | 2 | Word length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| rd_en | input | 1 | Remove the head entry |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Head character, right-aligned |
| rd_par_err | output | 1 | Head parity error tag |
| rd_frm_err | output | 1 | Head framing error tag |
| rd_brk | output | 1 | Head break tag |
| rd_ovr | output | 1 | Head overrun tag |

## Verification
The assertions assume the following about the inputs:
- the frame configuration stays constant while a frame is being received;
- `tick16` is a single-cycle pulse, never high on two consecutive clocks;
- `rx_line` changes slowly compared with the tick.

The stimulus meets these assumptions. It changes the configuration only while the line is idle between frames. It generates the tick from a free-running divider as one pulse every four clocks. It holds each bit level for exactly sixteen ticks, so every centre sample falls well inside a stable bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rx_word_t;

  function automatic logic [2:0] last_bit_idx(input logic [1:0] wlen);
    return 3'(wlen) + 3'd4;
  endfunction

  function automatic logic [7:0] right_align(input logic [7:0] sh, input logic [1:0] wlen);
    case (wlen)
      2'd0:    return {3'b0, sh[7:3]};
      2'd1:    return {2'b0, sh[7:2]};
      2'd2:    return {1'b0, sh[7:1]};
      default: return sh;
    endcase
  endfunction

  function automatic logic parity_bad(input logic [7:0] data, input logic pbit,
                                      input logic en, input logic odd);
    return en & ((^data) ^ pbit ^ odd);
  endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       tick16,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  output logic       frame_done,
  output rx_word_t   frame_word
);
  localparam int SYNC = 2;
  localparam logic [3:0] START_CHK = 4'd7;
  localparam logic [3:0] BIT_LAST  = 4'd15;

  logic [SYNC-1:0] sync_q;
  logic            rxs;
  rx_state_e       state;
  logic [3:0]      cnt;
  logic [2:0]      bidx;
  logic [7:0]      sh;
  logic            parb, frm, allz, stopn;
  logic            mid_sample, start_ok, start_false;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rx_line};
  assign rxs = sync_q[SYNC-1];

  assign mid_sample  = tick16 && (cnt == BIT_LAST) &&
                       (state == RX_DATA || state == RX_PAR || state == RX_STOP);
  assign start_ok    = tick16 && state == RX_START && cnt == START_CHK && !rxs;
  assign start_false = tick16 && state == RX_START && cnt == START_CHK && rxs;
  assign frame_done  = mid_sample && state == RX_STOP && (!cfg_stop2 || stopn);

  always_comb begin
    frame_word      = '0;
    frame_word.data = right_align(sh, cfg_wlen);
    frame_word.par  = parity_bad(frame_word.data, parb, cfg_par_en, cfg_par_odd);
    frame_word.frm  = frm | !rxs;
    frame_word.brk  = allz & !rxs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE; cnt <= '0; bidx <= '0; sh <= '0;
      parb <= 1'b0; frm <= 1'b0; allz <= 1'b0; stopn <= 1'b0;
    end else begin
      case (state)
        RX_IDLE: if (tick16 && !rxs) begin
          state <= RX_START; cnt <= 4'd1;
        end
        RX_START: if (tick16) begin
          if (start_false) state <= RX_IDLE;
          else if (start_ok) begin
            state <= RX_DATA; cnt <= '0; bidx <= '0;
            allz <= 1'b1; frm <= 1'b0; stopn <= 1'b0; parb <= 1'b0;
          end else cnt <= cnt + 4'd1;
        end
        RX_HOLD: if (rxs) state <= RX_IDLE;
        default: if (tick16) begin
          cnt <= mid_sample ? 4'd0 : cnt + 4'd1;
          if (mid_sample) begin
            allz <= allz & !rxs;
            if (state == RX_DATA) begin
              sh <= {rxs, sh[7:1]};
              if (bidx == last_bit_idx(cfg_wlen)) state <= cfg_par_en ? RX_PAR : RX_STOP;
              else bidx <= bidx + 3'd1;
            end else if (state == RX_PAR) begin
              parb <= rxs; state <= RX_STOP;
            end else begin
              frm <= frm | !rxs;
              if (frame_done) state <= rxs ? RX_IDLE : RX_HOLD;
              else stopn <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R1
  property p_false_start;
    @(posedge clk) disable iff (!rst_n) start_false |=> state == RX_IDLE;
  endproperty
  false_start_chk: assert property (p_false_start);

  // R5
  property p_brk_frm;
    @(posedge clk) disable iff (!rst_n) (frame_done && frame_word.brk) |-> frame_word.frm;
  endproperty
  brk_implies_frm_chk: assert property (p_brk_frm);

  // R5
  property p_hold_wait;
    @(posedge clk) disable iff (!rst_n) (state == RX_HOLD && !rxs) |=> state == RX_HOLD;
  endproperty
  hold_wait_chk: assert property (p_hold_wait);

  // R3
  property p_par_off;
    @(posedge clk) disable iff (!rst_n) (frame_done && !cfg_par_en) |-> !frame_word.par;
  endproperty
  par_off_chk: assert property (p_par_off);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign valid   = (count != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign dout    = mem[rp];

  always_ff @(posedge clk) if (do_push) mem[wp] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R6
  property p_bound;
    @(posedge clk) disable iff (!rst_n) count <= (AW+1)'(DEPTH);
  endproperty
  count_bound_chk: assert property (p_bound);

  // R6
  property p_empty_pop;
    @(posedge clk) disable iff (!rst_n) (pop && !valid && !push) |=> !valid;
  endproperty
  empty_pop_chk: assert property (p_empty_pop);
endmodule

// File: rtl/uart_rx_tag.sv
module uart_rx_tag
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       tick16,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       rd_en,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_par_err,
  output logic       rd_frm_err,
  output logic       rd_brk,
  output logic       rd_ovr
);
  localparam int WW = $bits(rx_word_t);

  logic     frame_done, fifo_full, ovr_pend, drop_evt;
  rx_word_t frame_word, push_word, head;
  logic [WW-1:0] head_bits;

  uart_rx_frame u_frame (
    .clk, .rst_n, .rx_line, .tick16, .cfg_wlen, .cfg_par_en, .cfg_par_odd,
    .cfg_stop2, .frame_done, .frame_word
  );

  assign drop_evt = frame_done && fifo_full;

  always_comb begin
    push_word     = frame_word;
    push_word.ovr = ovr_pend;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          ovr_pend <= 1'b0;
    else if (drop_evt)   ovr_pend <= 1'b1;
    else if (frame_done) ovr_pend <= 1'b0;

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(WW)) u_fifo (
    .clk, .rst_n, .push(frame_done), .din(push_word), .pop(rd_en),
    .dout(head_bits), .valid(rd_valid), .full(fifo_full)
  );

  assign head       = rx_word_t'(head_bits);
  assign rd_data    = head.data;
  assign rd_par_err = head.par;
  assign rd_frm_err = head.frm;
  assign rd_brk     = head.brk;
  assign rd_ovr     = head.ovr;

  // R7
  property p_drop_pend;
    @(posedge clk) disable iff (!rst_n) drop_evt |=> ovr_pend;
  endproperty
  drop_pend_chk: assert property (p_drop_pend);

  // R7
  property p_store_clears;
    @(posedge clk) disable iff (!rst_n) (frame_done && !fifo_full) |=> !ovr_pend;
  endproperty
  store_clears_chk: assert property (p_store_clears);
endmodule

// File: tb/sim_uart_rx_tag.sv
module sim_uart_rx_tag;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int NVEC       = 6;
  // {wlen[14:13], par_en, odd, stop2, data[9:2], bad_par, bad_stop}
  localparam logic [14:0] VEC [NVEC] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b0},
    {2'd1, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1}
  };

  logic clk = 0, rst_n = 0, rx_line = 1, rd_en = 0;
  logic [1:0] cfg_wlen = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0;
  logic rd_valid, rd_par_err, rd_frm_err, rd_brk, rd_ovr;
  logic [7:0] rd_data;
  logic [1:0] div = 0;
  logic tick16;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) div <= div + 2'd1;
  assign tick16 = (div == 2'd0);

  uart_rx_tag u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rx_line = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    int n = 5 + int'(cfg_wlen);
    logic p = cfg_par_odd;
    hold_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      hold_bit(d[i]);
      p ^= d[i];
    end
    if (cfg_par_en) hold_bit(p ^ bad_par);
    hold_bit(!bad_stop);
    if (cfg_stop2) hold_bit(1'b1);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic read_expect(input string req, input logic [7:0] d, input logic par,
                             input logic frm, input logic brk, input logic ovr);
    chk({req, " valid"}, 32'(rd_valid), 32'd1);
    chk({req, " data"}, 32'(rd_data), 32'(d));
    chk({req, " tags"}, {28'd0, rd_ovr, rd_brk, rd_frm_err, rd_par_err},
        {28'd0, ovr, brk, frm, par});
    rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset empty", 32'(rd_valid), 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] m;
      cfg_wlen = VEC[v][14:13]; cfg_par_en = VEC[v][12];
      cfg_par_odd = VEC[v][11]; cfg_stop2 = VEC[v][10];
      m = VEC[v][9:2] & 8'(8'hFF >> (3 - int'(VEC[v][14:13])));
      send(VEC[v][9:2], VEC[v][1], VEC[v][0]);
      read_expect("R2/R3/R4 vector", m, VEC[v][1], VEC[v][0], 1'b0, 1'b0);
    end

    cfg_wlen = 2'd3; cfg_par_en = 0; cfg_par_odd = 0; cfg_stop2 = 0;

    // R1 false start: low for 3 bit-ticks only
    rx_line = 0; repeat (3 * TICK_DIV) @(negedge clk);
    hold_bit(1'b1); hold_bit(1'b1);
    chk("R1 false start stores nothing", 32'(rd_valid), 32'd0);

    // R6 read on empty ignored, then a normal character
    rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
    chk("R6 empty read", 32'(rd_valid), 32'd0);
    send(8'h3E, 1'b0, 1'b0);
    read_expect("R6 after empty read", 8'h3E, 1'b0, 1'b0, 1'b0, 1'b0);

    // R5 break: line low for 14 bit times, then high
    for (int i = 0; i < 14; i++) hold_bit(1'b0);
    hold_bit(1'b1); hold_bit(1'b1);
    read_expect("R5 break", 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R5 single break entry", 32'(rd_valid), 32'd0);

    // R7 overrun
    for (int i = 0; i < 16; i++) send(8'(i), 1'b0, 1'b0);
    send(8'h77, 1'b0, 1'b0);
    read_expect("R7 head after drop", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h99, 1'b0, 1'b0);
    for (int i = 1; i < 16; i++)
      read_expect("R7 old entries", 8'(i), 1'b0, 1'b0, 1'b0, 1'b0);
    read_expect("R7 tagged entry", 8'h99, 1'b0, 1'b0, 1'b0, 1'b1);
    send(8'h42, 1'b0, 1'b0);
    read_expect("R7 tag cleared", 8'h42, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 drained", 32'(rd_valid), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule